// File: doc/BRIEF.md
# SPI FIFO and Interrupt Status Unit

This unit sits between a register port and the shift engine of an SPI controller. It holds one 64-byte transmit queue and one 64-byte receive queue. Software pushes bytes by writing the TX data address and pops bytes by reading the RX data address. The shift engine drains the TX queue and fills the RX queue through single-cycle pop and push strobes.

A FIFO control word holds a trigger level for each queue and one reset bit for each queue. A reset bit clears itself once the flush is done, so software can write a reset and then poll the control word until that bit reads zero. A status word gives both fill counts. A 14-bit sticky interrupt status register collects level conditions, overflow and underflow events, and two engine events. It is cleared by writing ones, and it is masked by an enable register into a single interrupt line.

The register port is a plain single-cycle interface. Read data is combinational from the current address. A read strobe on the RX data address pops the queue at the next clock edge.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset both queues are empty. The control word, the status word and the enable register read zero, and `irq_o` and `eng_tx_valid_o` are low.
- R2: A write to the TX data address (address 4) appends `wdata[7:0]`. The engine sees the oldest byte on `eng_tx_data_o` with `eng_tx_valid_o` high, and a pop strobe advances the queue in first-in order. The TX count is in bits 23:16 of the status word (address 1).
- R3: An engine push stores `eng_rx_data_i`. A read of the RX data address (address 5) returns the oldest byte in bits 7:0 and pops it. The RX count is in bits 7:0 of the status word.
- R4: Each queue holds 64 bytes. A push into a full queue is dropped and the count stays at 64. A dropped TX push sets status bit 10, and a dropped RX push sets status bit 8.
- R5: A pop from an empty queue returns zero. An RX data read sets status bit 9, and an engine TX pop sets status bit 11.
- R6: In the control word (address 0), writing 1 to bit 31 flushes the TX queue and writing 1 to bit 15 flushes the RX queue. The other queue is untouched. The bit reads 1 in the cycle after the write and 0 from the following cycle on.
- R7: The TX trigger level is in control bits 23:16 and the RX trigger level is in control bits 7:0. Both read back. Status bit 4 is set while the TX count is at or below the TX level. Status bit 0 is set while the RX count is at or above the RX level.
- R8: Status bit 1 is set while RX is empty, bit 2 while RX is full, bit 5 while TX is empty, and bit 6 while TX is full.
- R9: `eng_done_i` sets status bit 12 and `eng_cs_release_i` sets status bit 13.
- R10: Status bits (address 3) are sticky. Writing 1 clears a bit, and writing 0 has no effect. A level condition that still holds sets its bit again at the clearing edge.
- R11: `irq_o` is high when any status bit is set together with the same bit of the enable register (address 2). Only bits 0-2, 4-6 and 8-13 exist in the enable and status registers; the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops RX on address 5) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address |
| eng_tx_pop_i | input | 1 | Engine takes the head TX byte |
| eng_tx_data_o | output | 8 | Head TX byte, zero when empty |
| eng_tx_valid_o | output | 1 | TX queue is not empty |
| eng_rx_push_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| eng_done_i | input | 1 | Transfer complete event |
| eng_cs_release_i | input | 1 | Chip select released event |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A wrong pointer or count shows up at once as a wrong fill count in the status word. It also shows up as a byte out of order on the next pop. Running each queue through a full 64-entry wrap exposes a pointer that wraps at the wrong point within one pass. Status faults surface one cycle after the cause, because each flag is registered from the counts of the previous cycle. A flag that fails to set again after a write-one clear, or a mask bit that is dropped, is visible directly on `irq_o` in the cycle after the register write.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int REG_AW = 3;
  localparam int BYTE_W = 8;
  localparam int IRQ_W  = 14;

  localparam logic [REG_AW-1:0] A_FCTL  = 3'd0;
  localparam logic [REG_AW-1:0] A_FSTAT = 3'd1;
  localparam logic [REG_AW-1:0] A_IEN   = 3'd2;
  localparam logic [REG_AW-1:0] A_ISTAT = 3'd3;
  localparam logic [REG_AW-1:0] A_TXD   = 3'd4;
  localparam logic [REG_AW-1:0] A_RXD   = 3'd5;

  localparam int FC_TX_RST = 31;
  localparam int FC_RX_RST = 15;

  localparam int IB_RX_RDY = 0;
  localparam int IB_RX_EMP = 1;
  localparam int IB_RX_FUL = 2;
  localparam int IB_TX_REQ = 4;
  localparam int IB_TX_EMP = 5;
  localparam int IB_TX_FUL = 6;
  localparam int IB_RX_OVF = 8;
  localparam int IB_RX_UDF = 9;
  localparam int IB_TX_OVF = 10;
  localparam int IB_TX_UDF = 11;
  localparam int IB_DONE   = 12;
  localparam int IB_CS_REL = 13;

  localparam logic [IRQ_W-1:0] IRQ_IMPL = 14'h3F77;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          push_i,
  input  logic [DW-1:0]                 wdata_i,
  input  logic                          pop_i,
  output logic [DW-1:0]                 rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]    count_o,
  output logic                          empty_o,
  output logic                          full_o,
  output logic                          ovf_o,
  output logic                          udf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign ovf_o   = push_i & full_o & ~flush_i;
  assign udf_o   = pop_i & empty_o & ~flush_i;
  assign rdata_o = empty_o ? '0 : mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= ptr_inc(wptr_q);
      if (pop_ok)  rptr_q <= ptr_inc(rptr_q);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  p_count_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(cnt_q));
  p_empty_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rdata_o == '0));
  p_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int             W    = 14,
  parameter logic [W-1:0]   IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] clr_v;
  logic         bits_unused;

  assign clr_v       = clr_we_i ? wdata_i : '0;
  assign bits_unused = ^{set_i & ~IMPL, wdata_i & ~IMPL};

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stat_o[b] <= 1'b0;
          en_o[b]   <= 1'b0;
        end else begin
          if (set_i[b])      stat_o[b] <= 1'b1;
          else if (clr_v[b]) stat_o[b] <= 1'b0;
          if (en_we_i)       en_o[b]   <= wdata_i[b];
        end
      end
    end else begin : g_tie
      assign stat_o[b] = 1'b0;
      assign en_o[b]   = 1'b0;
    end
  end

  assign irq_o = |(stat_o & en_o);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & $past(stat_o & ~clr_v)) == $past(stat_o & ~clr_v)));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & $past(clr_v & ~set_i)) == '0));
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              eng_tx_pop_i,
  output logic [BYTE_W-1:0] eng_tx_data_o,
  output logic              eng_tx_valid_o,
  input  logic              eng_rx_push_i,
  input  logic [BYTE_W-1:0] eng_rx_data_i,
  input  logic              eng_done_i,
  input  logic              eng_cs_release_i,
  output logic              irq_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic wr_fctl, wr_ien, wr_istat, wr_txd, rd_rxd;
  logic tx_rst_q, rx_rst_q;
  logic [7:0] tx_trig_q, rx_trig_q;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0] tx_cnt8, rx_cnt8;
  logic tx_emp, tx_ful, tx_ovf, tx_udf;
  logic rx_emp, rx_ful, rx_ovf, rx_udf;
  logic [BYTE_W-1:0] rx_head;
  logic [IRQ_W-1:0] set_v, istat, ien;
  logic wdata_unused;

  assign wr_fctl  = reg_we_i && (reg_addr_i == A_FCTL);
  assign wr_ien   = reg_we_i && (reg_addr_i == A_IEN);
  assign wr_istat = reg_we_i && (reg_addr_i == A_ISTAT);
  assign wr_txd   = reg_we_i && (reg_addr_i == A_TXD);
  assign rd_rxd   = reg_re_i && (reg_addr_i == A_RXD);
  assign wdata_unused = ^{reg_wdata_i[30:24], reg_wdata_i[14:8]};

  // reset bits hold for one cycle, flush happens on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_rst_q  <= 1'b0;
      rx_rst_q  <= 1'b0;
      tx_trig_q <= '0;
      rx_trig_q <= '0;
    end else if (wr_fctl) begin
      tx_rst_q  <= reg_wdata_i[FC_TX_RST];
      rx_rst_q  <= reg_wdata_i[FC_RX_RST];
      tx_trig_q <= reg_wdata_i[23:16];
      rx_trig_q <= reg_wdata_i[7:0];
    end else begin
      tx_rst_q  <= 1'b0;
      rx_rst_q  <= 1'b0;
    end
  end

  spi_byte_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_rst_q),
    .push_i  (wr_txd),
    .wdata_i (reg_wdata_i[BYTE_W-1:0]),
    .pop_i   (eng_tx_pop_i),
    .rdata_o (eng_tx_data_o),
    .count_o (tx_cnt),
    .empty_o (tx_emp),
    .full_o  (tx_ful),
    .ovf_o   (tx_ovf),
    .udf_o   (tx_udf)
  );

  spi_byte_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_rst_q),
    .push_i  (eng_rx_push_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (rd_rxd),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .empty_o (rx_emp),
    .full_o  (rx_ful),
    .ovf_o   (rx_ovf),
    .udf_o   (rx_udf)
  );

  assign eng_tx_valid_o = ~tx_emp;
  assign tx_cnt8 = 8'(tx_cnt);
  assign rx_cnt8 = 8'(rx_cnt);

  always_comb begin
    set_v            = '0;
    set_v[IB_RX_RDY] = (rx_cnt8 >= rx_trig_q);
    set_v[IB_RX_EMP] = rx_emp;
    set_v[IB_RX_FUL] = rx_ful;
    set_v[IB_TX_REQ] = (tx_cnt8 <= tx_trig_q);
    set_v[IB_TX_EMP] = tx_emp;
    set_v[IB_TX_FUL] = tx_ful;
    set_v[IB_RX_OVF] = rx_ovf;
    set_v[IB_RX_UDF] = rx_udf;
    set_v[IB_TX_OVF] = tx_ovf;
    set_v[IB_TX_UDF] = tx_udf;
    set_v[IB_DONE]   = eng_done_i;
    set_v[IB_CS_REL] = eng_cs_release_i;
  end

  spi_irq_status #(.W(IRQ_W), .IMPL(IRQ_IMPL)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_v),
    .clr_we_i (wr_istat),
    .en_we_i  (wr_ien),
    .wdata_i  (reg_wdata_i[IRQ_W-1:0]),
    .stat_o   (istat),
    .en_o     (ien),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_FCTL:  reg_rdata_o = {tx_rst_q, 7'b0, tx_trig_q, rx_rst_q, 7'b0, rx_trig_q};
      A_FSTAT: reg_rdata_o = {8'b0, tx_cnt8, 8'b0, rx_cnt8};
      A_IEN:   reg_rdata_o = {{(32-IRQ_W){1'b0}}, ien};
      A_ISTAT: reg_rdata_o = {{(32-IRQ_W){1'b0}}, istat};
      A_RXD:   reg_rdata_o = {{(32-BYTE_W){1'b0}}, rx_head};
      default: reg_rdata_o = '0;
    endcase
  end

  p_txreq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt8 <= tx_trig_q) |=> istat[IB_TX_REQ]);
  p_rxrdy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt8 >= rx_trig_q) |=> istat[IB_RX_RDY]);
  p_rx_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rxd && !rx_emp && !eng_rx_push_i && !rx_rst_q) |=> (rx_cnt == $past(rx_cnt) - 1'b1));
  p_ovf_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_txd && tx_ful && !tx_rst_q) |=> istat[IB_TX_OVF]);
  p_selfclear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_rst_q && !wr_fctl) |=> (!tx_rst_q && tx_emp));
endmodule

// File: tb/sim_spi_fifo_irq.sv
module sim_spi_fifo_irq;
  localparam logic [2:0] AF = 3'd0, AS = 3'd1, AE = 3'd2, AI = 3'd3, AT = 3'd4, AR = 3'd5;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, AE, 32'h0,          32'h0},          // R11 mask off
    '{OP_WR, AT, 32'hA5,         32'h0},          // R2 push
    '{OP_WR, AT, 32'h3C,         32'h0},          // R2 push
    '{OP_RD, AS, 32'h0,          32'h0002_0000},  // R2 tx count field
    '{OP_WR, AF, 32'h0005_0002,  32'h0},          // R7 levels
    '{OP_RD, AF, 32'h0,          32'h0005_0002},  // R7 readback
    '{OP_RD, AR, 32'h0,          32'h0},          // R5 empty pop reads zero
    '{OP_RD, AI, 32'h0,          32'h0000_0233},  // R5 R8 sticky bits
    '{OP_WR, AI, 32'h0,          32'h0},          // R10 write zero
    '{OP_RD, AI, 32'h0,          32'h0000_0233},  // R10 unchanged
    '{OP_WR, AI, 32'hFFFF_FFFF,  32'h0},          // R10 clear all
    '{OP_RD, AI, 32'h0,          32'h0000_0012},  // R10 levels re-set
    '{OP_RD, AT, 32'h0,          32'h0}           // TX data address reads zero
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic tx_pop = 1'b0, tx_valid, rx_push = 1'b0, done = 1'b0, csr = 1'b0, irq;
  logic [7:0] tx_data, rx_data = '0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_fifo_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .eng_tx_pop_i(tx_pop),
    .eng_tx_data_o(tx_data), .eng_tx_valid_o(tx_valid), .eng_rx_push_i(rx_push),
    .eng_rx_data_i(rx_data), .eng_done_i(done), .eng_cs_release_i(csr), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    re = 1'b0;
  endtask

  task automatic eng_pop(output logic [7:0] d);
    d = tx_data; tx_pop = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] d);
    rx_data = d; rx_push = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pulse(input bit which);
    if (which) csr = 1'b1; else done = 1'b1;
    @(posedge clk); @(negedge clk);
    csr = 1'b0; done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    rd(AF, r); chk("R1 ctrl", r, 32'h0);
    rd(AS, r); chk("R1 fstat", r, 32'h0);
    rd(AE, r); chk("R1 ien", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == OP_WR) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, r);
        chk($sformatf("vector %0d", i), r, VECS[i].exp);
      end
    end

    // R2 engine drains in order
    chk("R2 valid", {31'b0, tx_valid}, 32'h1);
    eng_pop(b); chk("R2 first byte", {24'b0, b}, 32'hA5);
    eng_pop(b); chk("R2 second byte", {24'b0, b}, 32'h3C);
    chk("R2 valid low", {31'b0, tx_valid}, 32'h0);
    // R5 engine pop on empty
    eng_pop(b); chk("R5 tx empty pop data", {24'b0, b}, 32'h0);
    rd(AI, r); chk("R5 tx underflow", r & 32'h820, 32'h820);

    // R4 R8 TX full and overflow
    wr(AI, 32'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) wr(AT, 32'(i));
    wr(AT, 32'hEE);
    rd(AS, r); chk("R4 tx count 64", r, 32'h0040_0000);
    rd(AI, r); chk("R4 R8 tx full+ovf", r & 32'h440, 32'h440);
    for (int i = 0; i < 64; i++) begin
      eng_pop(b); chk("R2 tx order", {24'b0, b}, 32'(i));
    end

    // R3 R4 R8 RX full and overflow
    wr(AI, 32'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) eng_push(8'(i) ^ 8'h5A);
    eng_push(8'hEE);
    rd(AS, r); chk("R4 rx count 64", r, 32'h0000_0040);
    rd(AI, r); chk("R4 R8 rx full+ovf+ready", r & 32'h105, 32'h105);
    for (int i = 0; i < 64; i++) begin
      rd(AR, r); chk("R3 rx order", r, 32'(8'(i) ^ 8'h5A));
    end
    rd(AS, r); chk("R3 rx drained", r, 32'h0);

    // R7 thresholds
    wr(AF, 32'h0005_0003);
    wr(AI, 32'hFFFF_FFFF);
    eng_push(8'h11); eng_push(8'h22);
    @(negedge clk);
    rd(AI, r); chk("R7 rx below level", r & 32'h1, 32'h0);
    eng_push(8'h33);
    @(negedge clk);
    rd(AI, r); chk("R7 rx at level", r & 32'h1, 32'h1);
    for (int i = 0; i < 6; i++) wr(AT, 32'h70 + 32'(i));
    wr(AI, 32'hFFFF_FFFF);
    rd(AI, r); chk("R7 tx above level", r & 32'h10, 32'h0);

    // R6 self-clearing flushes
    wr(AF, 32'h8005_0003);
    rd(AF, r); chk("R6 tx rst visible", r, 32'h8005_0003);
    rd(AF, r); chk("R6 tx rst cleared", r, 32'h0005_0003);
    rd(AS, r); chk("R6 tx flushed rx kept", r, 32'h0000_0003);
    wr(AF, 32'h0005_8003);
    @(negedge clk);
    rd(AS, r); chk("R6 rx flushed", r, 32'h0);
    rd(AF, r); chk("R6 ctrl after rx rst", r, 32'h0005_0003);

    // R9 engine events
    wr(AI, 32'hFFFF_FFFF);
    pulse(1'b0);
    rd(AI, r); chk("R9 done", r & 32'h3000, 32'h1000);
    pulse(1'b1);
    rd(AI, r); chk("R9 cs release", r & 32'h3000, 32'h3000);

    // R11 masking
    wr(AE, 32'hFFFF_FFFF);
    rd(AE, r); chk("R11 enable map", r, 32'h0000_3F77);
    wr(AE, 32'h1000);
    chk("R11 irq on done", {31'b0, irq}, 32'h1);
    wr(AI, 32'h1000);
    chk("R11 irq after clear", {31'b0, irq}, 32'h0);
    wr(AE, 32'h2);
    chk("R11 irq rx empty", {31'b0, irq}, 32'h1);
    wr(AE, 32'h0);
    chk("R11 irq masked", {31'b0, irq}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule